// File: doc/BRIEF.md
# Prescaled Timer Counter Unit

This block is an 8-bit up-counter for a small microcontroller subsystem. Its count pulses come either from a free-running prescaler fed by the system clock, or from edges on an external count input. That input is first brought into the system clock domain through a two-stage synchroniser. A 3-bit selector chooses the pulse source. When the count rolls over from its top value back to zero, the unit raises an overflow flag. The unit drives an interrupt request line whenever that flag is set, its enable bit is set and the global enable input is high.

Software reaches the unit through a plain register port. The port has a 2-bit address, 8-bit write data, a write strobe and combinational read data. The four registers are: select control at address 0, count value at address 1, interrupt enable at address 2, and overflow flag at address 3. The flag is cleared by writing a one to it, or by pulsing the acknowledge input.

Top module: `tmr8_unit`

## Requirements
- R1: After reset, all four registers read zero, the prescaler is zero and `irq_o` is low.
- R2: With select value 0 (control bits [2:0] at address 0), the count does not change.
- R3: Select values 1, 2, 3, 4 and 5 advance the count once every 1, 8, 64, 256 and 1024 system clocks. A pulse occurs in the cycle in which the low 0, 3, 6, 8 or 10 bits of the free-running 10-bit prescaler are all ones. The prescaler starts from zero at reset.
- R4: Select value 6 advances the count once per high-to-low transition of `ext_cnt_i`. The input is sampled by two flops and compared with a third, so the count changes on the third rising clock edge after the first clock edge that samples the new low level.
- R5: Select value 7 advances the count once per low-to-high transition of `ext_cnt_i`, with the same latency as R4.
- R6: An advance from 255 wraps the count to 0 and sets the overflow flag (bit 0 at address 3).
- R7: A write to address 1 loads the count and takes priority over an advance in the same cycle; that cycle produces no overflow.
- R8: The flag clears on a write with bit 0 set to address 3, or on `irq_ack_i`. An overflow in the same cycle wins, and the flag stays set.
- R9: `irq_o` is high exactly when the flag, bit 0 at address 2 and `gie_i` are all one.
- R10: Bits [7:3] at address 0 and bits [7:1] at addresses 2 and 3 read as zero whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_cnt_i | input | 1 | External count input, asynchronous |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Two pairs of events can land in the same cycle. An overflow can meet a flag clear, from an acknowledge or a write-one, and a count write can meet a prescaler pulse. The bench provokes the first pair by loading 254 with the divide-by-1 selection and then driving both clear paths on the wrap edge; the flag must read one afterwards. It provokes the second pair by writing the count while the divide-by-1 selection is active, so every write meets a pulse, and the behavioural model predicts the loaded value with no overflow.

// File: rtl/tmr8_unit.sv
module tmr8_unit #(
  parameter int CW   = 8,
  parameter int SW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_cnt_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [CW-1:0] reg_wdata_i,
  input  logic          reg_we_i,
  output logic [CW-1:0] reg_rdata_o,
  input  logic          gie_i,
  input  logic          irq_ack_i,
  output logic          irq_o
);
  localparam int NTAP = 5;
  localparam int TAPW [0:NTAP-1] = '{0, 3, 6, 8, 10};
  localparam int PW = TAPW[NTAP-1];
  localparam logic [1:0] A_CTL = 2'd0, A_CNT = 2'd1, A_MSK = 2'd2, A_FLG = 2'd3;

  logic [PW-1:0]   pre_q;
  logic [NTAP-1:0] tap;
  logic [SYNC:0]   ext_sh;
  logic [SW-1:0]   ctl_q;
  logic [CW-1:0]   cnt_q;
  logic            en_q, flag_q, inc_en;

  wire ext_now  = ext_sh[SYNC-1];
  wire ext_old  = ext_sh[SYNC];
  wire cnt_wr   = reg_we_i && reg_addr_i == A_CNT;
  wire flag_clr = irq_ack_i || (reg_we_i && reg_addr_i == A_FLG && reg_wdata_i[0]);
  wire wrap     = inc_en && (&cnt_q) && !cnt_wr;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    if (TAPW[i] == 0) begin : g_all
      assign tap[i] = 1'b1;
    end else begin : g_div
      assign tap[i] = &pre_q[TAPW[i]-1:0];
    end
  end

  always_comb begin
    case (ctl_q)
      3'd0:    inc_en = 1'b0;
      3'd6:    inc_en = ext_old && !ext_now;
      3'd7:    inc_en = !ext_old && ext_now;
      default: inc_en = tap[ctl_q - 3'd1];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ext_sh <= '0;
      ctl_q  <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      ext_sh <= {ext_sh[SYNC-1:0], ext_cnt_i};
      if (reg_we_i && reg_addr_i == A_CTL) ctl_q <= reg_wdata_i[SW-1:0];
      if (reg_we_i && reg_addr_i == A_MSK) en_q <= reg_wdata_i[0];
      if (cnt_wr)      cnt_q <= reg_wdata_i;
      else if (inc_en) cnt_q <= cnt_q + 1'b1;
      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CTL:   reg_rdata_o = {{(CW-SW){1'b0}}, ctl_q};
      A_CNT:   reg_rdata_o = cnt_q;
      A_MSK:   reg_rdata_o = {{(CW-1){1'b0}}, en_q};
      default: reg_rdata_o = {{(CW-1){1'b0}}, flag_q};
    endcase
  end

  assign irq_o = flag_q && en_q && gie_i;
endmodule

// File: rtl/tmr8_unit_chk.sv
module tmr8_unit_chk #(
  parameter int CW = 8,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_addr_i,
  input logic [CW-1:0] reg_wdata_i,
  input logic          reg_we_i,
  input logic [CW-1:0] reg_rdata_o,
  input logic          gie_i,
  input logic          irq_ack_i,
  input logic          irq_o,
  input logic [SW-1:0] ctl_q,
  input logic [CW-1:0] cnt_q,
  input logic          flag_q,
  input logic          inc_en
);
  wire wr_cnt = reg_we_i && reg_addr_i == 2'd1;
  wire at_top = cnt_q == {CW{1'b1}};

  p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == '0 && !wr_cnt) |=> $stable(cnt_q));

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !wr_cnt && !at_top) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_wrap_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && at_top && !wr_cnt) |=> (flag_q && cnt_q == '0));

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(reg_wdata_i));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && !(inc_en && at_top && !wr_cnt)) |=> !flag_q);

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> !irq_o);

  p_ctl_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr_i == 2'd0 |-> reg_rdata_o[CW-1:SW] == '0);
endmodule

bind tmr8_unit tmr8_unit_chk #(.CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_we_i(reg_we_i), .reg_rdata_o(reg_rdata_o), .gie_i(gie_i),
  .irq_ack_i(irq_ack_i), .irq_o(irq_o), .ctl_q(ctl_q), .cnt_q(cnt_q),
  .flag_q(flag_q), .inc_en(inc_en)
);

// File: tb/tmr8_unit_tb.sv
module tmr8_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0, ext = 1'b0, we = 1'b0, gie = 1'b0, ack = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  tmr8_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ext_cnt_i(ext), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_we_i(we), .reg_rdata_o(rdata), .gie_i(gie), .irq_ack_i(ack), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    total = 0, bad = 0;
  string tag = "R1";
  bit    done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int m_pre = 0, m_cnt = 0, m_ctl = 0, m_en = 0, m_flag = 0, m_div = 1;
  bit m_inc, m_ov;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_ctl = 0; m_en = 0; m_flag = 0;
      hist = '{0, 0, 0};
    end else begin
      case (m_ctl)
        1: m_div = 1;
        2: m_div = 8;
        3: m_div = 64;
        4: m_div = 256;
        default: m_div = 1024;
      endcase
      if (m_ctl == 0)      m_inc = 0;
      else if (m_ctl == 6) m_inc = hist[2] && !hist[1];
      else if (m_ctl == 7) m_inc = !hist[2] && hist[1];
      else                 m_inc = (m_pre % m_div) == m_div - 1;
      m_ov = 0;
      if (we && addr == 2'd1) m_cnt = wd;
      else if (m_inc) begin
        if (m_cnt == 255) begin m_cnt = 0; m_ov = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (m_ov) m_flag = 1;
      else if (ack || (we && addr == 2'd3 && wd[0])) m_flag = 0;
      if (we && addr == 2'd0) m_ctl = wd & 7;
      if (we && addr == 2'd2) m_en = wd[0];
      m_pre = (m_pre + 1) % 1024;
      hist.push_front(ext);
      void'(hist.pop_back());
    end
  end

  function automatic int exp_rd();
    case (addr)
      2'd0: return m_ctl;
      2'd1: return m_cnt;
      2'd2: return m_en;
      default: return m_flag;
    endcase
  endfunction

  task automatic chk(string t, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%0h expected=%0h at %0t", t, addr, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(tag, int'(rdata), exp_rd());
    chk({tag, "/irq R9"}, int'(irq), (m_flag && m_en && gie) ? 1 : 0);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wd = d;
    cyc();
    we = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      addr = 2'(i);
      cyc();
    end
  endtask

  task automatic run_ext(int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] != 3'd0) ext = lfsr[5];
      addr = (i % 3 == 0) ? 2'd1 : 2'(i);
      cyc();
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    tag = "R1";
    run(4);
    @(negedge clk); rst_n = 1'b1;
    run(8);

    tag = "R10";
    wr(2'd0, 8'hF8); addr = 2'd0; cyc(); chk("R10 ctl upper", int'(rdata), 0);
    wr(2'd2, 8'hFE); addr = 2'd2; cyc(); chk("R10 mask upper", int'(rdata), 0);
    wr(2'd3, 8'hFE); addr = 2'd3; cyc(); chk("R10 flag upper", int'(rdata), 0);

    tag = "R2";
    wr(2'd1, 8'h5A); run(60);
    addr = 2'd1; cyc(); chk("R2 stopped count", int'(rdata), 8'h5A);

    tag = "R3";
    for (int s = 1; s <= 5; s++) begin
      wr(2'd1, 8'h00); wr(2'd0, 8'(s)); run(2100);
    end

    tag = "R4";
    wr(2'd0, 8'd0); wr(2'd1, 8'd0); ext = 1'b1; run(6); wr(2'd0, 8'd6);
    ext = 1'b0; addr = 2'd1;
    cyc(); cyc(); chk("R4 not yet counted", int'(rdata), 0);
    cyc(); chk("R4 fall counted 3rd edge", int'(rdata), 1);
    run_ext(400);

    tag = "R5";
    wr(2'd0, 8'd7); run_ext(400);

    tag = "R6";
    gie = 1'b1;
    wr(2'd2, 8'd1); wr(2'd0, 8'd1); wr(2'd1, 8'd250);
    run(12);
    addr = 2'd3; cyc(); chk("R6 flag after wrap", int'(rdata), 1);

    tag = "R9";
    gie = 1'b0; run(5); gie = 1'b1; run(5);
    wr(2'd2, 8'd0); run(4); wr(2'd2, 8'd1);
    ack = 1'b1; cyc(); ack = 1'b0; run(4);

    tag = "R8";
    wr(2'd3, 8'h01); run(3);
    wr(2'd1, 8'd254); cyc();
    ack = 1'b1; wr(2'd3, 8'h01); ack = 1'b0;
    chk("R8 overflow beats clear", int'(rdata), 1);
    wr(2'd3, 8'h01); addr = 2'd3; cyc(); chk("R8 write-one clears", int'(rdata), 0);

    tag = "R7";
    for (int k = 0; k < 300; k++) begin
      if (k % 5 == 0) wr(2'd1, 8'(k * 37));
      else begin addr = 2'(k); cyc(); end
    end
    wr(2'd1, 8'd255); addr = 2'd1; cyc(); chk("R7 load then step", int'(rdata), 0);

    tag = "R8";
    gie = 1'b1;
    for (int k = 0; k < 1200; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ack = (lfsr[4:0] == 5'd0);
      gie = lfsr[7] | lfsr[9];
      addr = 2'(k);
      cyc();
    end
    ack = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule